// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front-End

This block is the processor-facing side of an I2C master. It decodes a small word-addressed register window, holds a command queue and a receive queue between software and the bit-level bus engine, and keeps the clock divider settings, a local address and two byte counters. The engine itself sits outside and talks to this block through a plain set of strobes and levels.

Software queues command words through one data port and reads received bytes back through the same offset. It polls or waits on a single level interrupt. Two sticky event flags (transfer done and arbitration lost) are cleared by writing ones. All other status bits follow the engine and the queues live. A self-clearing soft-reset control bit holds the engine in reset for a fixed number of cycles and empties both queues.

Top module: `i2c_regfront`

## Requirements
- R1: After rst_ni is released, control reads 0, both divider registers read 0x00FF, both level registers read 0, status reads 0xA00 (RX empty bit 9 and TX empty bit 11 set), and irq_o is low.
- R2: A write at offset 0x00 pushes wdata bits 9:0 into the TX queue. The engine sees the words on eng_cmd_o in write order, eng_cmd_valid_o is high while the queue holds data, and offset 0x1C reads the entry count.
- R3: The TX queue holds 4 entries. When it is full, status bit 10 is set, bit 11 is clear, and a further write is dropped without changing the count or the queued data.
- R4: A read at offset 0x00 pops the RX queue and returns the byte in bits 7:0, in arrival order, with offset 0x18 giving the count. A read of an empty RX queue returns 0 and moves no pointer, and a push to a full RX queue (status bit 8 set) is dropped.
- R5: Status bit 0 (transfer done) and bit 1 (arbitration lost) are set by one-cycle engine pulses and stay set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: Status bits 2 (no acknowledge), 3 (data request), 5 (bus active), 6 (SCL level) and 7 (SDA level) follow their engine inputs live, and writes to status do not alter them.
- R7: Control bits 7:0, the SCL low divider at 0x0C, the SCL high divider at 0x10 and the 7-bit own address at 0x14 read back what was written, and the divider and address values drive their output ports.
- R8: Writing control bit 8 makes it read 1 and drives eng_reset_o high for RST_CYC cycles, after which both become 0. During that window both queues are emptied and the byte counters cleared.
- R9: irq_o is the OR of each control-enabled source: bit 0 transfer done, bit 1 arbitration lost, bit 2 no acknowledge, bit 3 data request, bit 5 RX full, bit 6 RX not empty, and bit 7 TX full. Bit 4 enables no source.
- R10: Offset 0x20 counts received bytes (eng_rx_push_i) and offset 0x24 counts transmitted bytes (eng_tx_byte_i). An eng_start_i pulse clears both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (pops the RX queue at offset 0x00) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Level interrupt |
| eng_cmd_o | output | 10 | Head of the TX command queue |
| eng_cmd_valid_o | output | 1 | TX queue not empty |
| eng_cmd_pop_i | input | 1 | Engine consumes the head command |
| eng_rx_data_i | input | 8 | Byte received by the engine |
| eng_rx_push_i | input | 1 | Push eng_rx_data_i into the RX queue |
| eng_done_i | input | 1 | Transfer done pulse |
| eng_arb_lost_i | input | 1 | Arbitration lost pulse |
| eng_nack_i | input | 1 | No acknowledge level |
| eng_drq_i | input | 1 | Engine requests data |
| eng_active_i | input | 1 | Bus active level |
| eng_scl_i | input | 1 | Sampled SCL line |
| eng_sda_i | input | 1 | Sampled SDA line |
| eng_start_i | input | 1 | START issued pulse |
| eng_tx_byte_i | input | 1 | One byte transmitted pulse |
| eng_reset_o | output | 1 | Soft reset to the engine |
| scl_low_o | output | 16 | SCL low divider |
| scl_high_o | output | 16 | SCL high divider |
| own_addr_o | output | 7 | Own address |

## Verification
The bench builds the block with its defaults: FIFO_DEPTH of 4, RST_CYC of 4, 16-bit dividers and counters. The shallow queues let it fill both queues and overrun them within a few accesses. The short reset window lets it watch the soft-reset bit rise and fall. It sweeps every interrupt source against every single enable bit, 56 combinations, and computes the expected interrupt level from a source vector modelled in the bench. That covers the overlap where RX full also raises RX not empty.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam logic [5:0] W_DATA = 6'd0;
  localparam logic [5:0] W_STAT = 6'd1;
  localparam logic [5:0] W_CTL  = 6'd2;
  localparam logic [5:0] W_SCLL = 6'd3;
  localparam logic [5:0] W_SCLH = 6'd4;
  localparam logic [5:0] W_OWN  = 6'd5;
  localparam logic [5:0] W_RXL  = 6'd6;
  localparam logic [5:0] W_TXL  = 6'd7;
  localparam logic [5:0] W_RXB  = 6'd8;
  localparam logic [5:0] W_TXB  = 6'd9;

  localparam int ST_TDI    = 0;
  localparam int ST_AFI    = 1;
  localparam int ST_NAI    = 2;
  localparam int ST_DRQ    = 3;
  localparam int ST_ACT    = 5;
  localparam int ST_SCL    = 6;
  localparam int ST_SDA    = 7;
  localparam int ST_RXFULL = 8;
  localparam int ST_RXEMPT = 9;
  localparam int ST_TXFULL = 10;
  localparam int ST_TXEMPT = 11;
  localparam int ST_W      = 12;

  localparam int CTL_SRST  = 8;
  localparam int CMD_W     = 10;
  localparam int BYTE_W    = 8;
  localparam int OWN_W     = 7;
endpackage

// File: rtl/i2c_rf_fifo.sv
module i2c_rf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 dout_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign dout_o  = empty_o ? '0 : mem[rp];
  assign level_o = cnt;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_level_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (level_o == $past(level_o)));
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/i2c_rf_status.sv
module i2c_rf_status
  import i2c_rf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_stat_i,
  input  logic [1:0]      w1c_i,
  input  logic            done_i,
  input  logic            arb_i,
  input  logic            nack_i,
  input  logic            drq_i,
  input  logic            active_i,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            rx_full_i,
  input  logic            rx_empty_i,
  input  logic            tx_full_i,
  input  logic            tx_empty_i,
  input  logic [7:0]      en_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);
  logic tdi_q, afi_q;
  logic [7:0] src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdi_q <= 1'b0;
      afi_q <= 1'b0;
    end else begin
      if (done_i)                  tdi_q <= 1'b1;
      else if (wr_stat_i && w1c_i[0]) tdi_q <= 1'b0;
      if (arb_i)                   afi_q <= 1'b1;
      else if (wr_stat_i && w1c_i[1]) afi_q <= 1'b0;
    end
  end

  always_comb begin
    stat_o            = '0;
    stat_o[ST_TDI]    = tdi_q;
    stat_o[ST_AFI]    = afi_q;
    stat_o[ST_NAI]    = nack_i;
    stat_o[ST_DRQ]    = drq_i;
    stat_o[ST_ACT]    = active_i;
    stat_o[ST_SCL]    = scl_i;
    stat_o[ST_SDA]    = sda_i;
    stat_o[ST_RXFULL] = rx_full_i;
    stat_o[ST_RXEMPT] = rx_empty_i;
    stat_o[ST_TXFULL] = tx_full_i;
    stat_o[ST_TXEMPT] = tx_empty_i;
  end

  // bit 4 enables slave data request, which has no source here
  assign src   = {tx_full_i, !rx_empty_i, rx_full_i, 1'b0, drq_i, nack_i, afi_q, tdi_q};
  assign irq_o = |(src & en_i);

  p_w1c_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && w1c_i[0] && !done_i) |=> !stat_o[ST_TDI]);
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[ST_AFI] && !(wr_stat_i && w1c_i[1])) |=> stat_o[ST_AFI]);
  p_rxavail_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i[6] && !rx_empty_i) |-> irq_o);
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
  import i2c_rf_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctl_i,
  input  logic             wr_scll_i,
  input  logic             wr_sclh_i,
  input  logic             wr_own_i,
  input  logic [8:0]       ctl_d_i,
  input  logic [DIV_W-1:0] div_d_i,
  input  logic [OWN_W-1:0] own_d_i,
  input  logic             start_i,
  input  logic             tx_byte_i,
  input  logic             rx_byte_i,
  output logic [7:0]       en_o,
  output logic             srst_o,
  output logic [DIV_W-1:0] scl_low_o,
  output logic [DIV_W-1:0] scl_high_o,
  output logic [OWN_W-1:0] own_o,
  output logic [CNT_W-1:0] rx_cnt_o,
  output logic [CNT_W-1:0] tx_cnt_o
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(8'hFF);

  logic [RW-1:0] srst_cnt;

  assign srst_o = (srst_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= '0;
      srst_cnt   <= '0;
      scl_low_o  <= DIV_RST;
      scl_high_o <= DIV_RST;
      own_o      <= '0;
    end else begin
      if (wr_ctl_i) en_o <= ctl_d_i[7:0];
      if (wr_ctl_i && ctl_d_i[CTL_SRST]) srst_cnt <= RW'(RST_CYC);
      else if (srst_o)                   srst_cnt <= srst_cnt - 1'b1;
      if (wr_scll_i) scl_low_o  <= div_d_i;
      if (wr_sclh_i) scl_high_o <= div_d_i;
      if (wr_own_i)  own_o      <= own_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cnt_o <= '0;
      tx_cnt_o <= '0;
    end else if (start_i || srst_o) begin
      rx_cnt_o <= '0;
      tx_cnt_o <= '0;
    end else begin
      if (rx_byte_i) rx_cnt_o <= rx_cnt_o + 1'b1;
      if (tx_byte_i) tx_cnt_o <= tx_cnt_o + 1'b1;
    end
  end

  p_srst_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_cnt <= RW'(RST_CYC));
  p_srst_selfclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_o && !wr_ctl_i) |=> (srst_cnt == RW'($past(srst_cnt) - 1'b1)));
  p_cnt_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (rx_cnt_o == '0 && tx_cnt_o == '0));
endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
  import i2c_rf_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 16,
  parameter int CNT_W      = 16,
  parameter int RST_CYC    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o,
  output logic [9:0]       eng_cmd_o,
  output logic             eng_cmd_valid_o,
  input  logic             eng_cmd_pop_i,
  input  logic [7:0]       eng_rx_data_i,
  input  logic             eng_rx_push_i,
  input  logic             eng_done_i,
  input  logic             eng_arb_lost_i,
  input  logic             eng_nack_i,
  input  logic             eng_drq_i,
  input  logic             eng_active_i,
  input  logic             eng_scl_i,
  input  logic             eng_sda_i,
  input  logic             eng_start_i,
  input  logic             eng_tx_byte_i,
  output logic             eng_reset_o,
  output logic [DIV_W-1:0] scl_low_o,
  output logic [DIV_W-1:0] scl_high_o,
  output logic [6:0]       own_addr_o
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic [5:0]       sel;
  logic             srst;
  logic [LW-1:0]    tx_lvl, rx_lvl;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]       rx_dout;
  logic [7:0]       en;
  logic [ST_W-1:0]  stat;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic             unused_bits;

  assign sel         = addr_i[7:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i[31:DIV_W]};
  assign eng_reset_o = srst;

  i2c_rf_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .flush_i (srst),
    .push_i  (wr_i && sel == W_DATA),
    .din_i   (wdata_i[CMD_W-1:0]),
    .pop_i   (eng_cmd_pop_i),
    .dout_o  (eng_cmd_o),
    .level_o (tx_lvl),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  i2c_rf_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .flush_i (srst),
    .push_i  (eng_rx_push_i),
    .din_i   (eng_rx_data_i),
    .pop_i   (rd_i && sel == W_DATA),
    .dout_o  (rx_dout),
    .level_o (rx_lvl),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign eng_cmd_valid_o = !tx_empty;

  i2c_rf_status u_stat (
    .clk_i, .rst_ni,
    .wr_stat_i  (wr_i && sel == W_STAT),
    .w1c_i      (wdata_i[1:0]),
    .done_i     (eng_done_i),
    .arb_i      (eng_arb_lost_i),
    .nack_i     (eng_nack_i),
    .drq_i      (eng_drq_i),
    .active_i   (eng_active_i),
    .scl_i      (eng_scl_i),
    .sda_i      (eng_sda_i),
    .rx_full_i  (rx_full),
    .rx_empty_i (rx_empty),
    .tx_full_i  (tx_full),
    .tx_empty_i (tx_empty),
    .en_i       (en),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  i2c_rf_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_regs (
    .clk_i, .rst_ni,
    .wr_ctl_i   (wr_i && sel == W_CTL),
    .wr_scll_i  (wr_i && sel == W_SCLL),
    .wr_sclh_i  (wr_i && sel == W_SCLH),
    .wr_own_i   (wr_i && sel == W_OWN),
    .ctl_d_i    (wdata_i[8:0]),
    .div_d_i    (wdata_i[DIV_W-1:0]),
    .own_d_i    (wdata_i[OWN_W-1:0]),
    .start_i    (eng_start_i),
    .tx_byte_i  (eng_tx_byte_i),
    .rx_byte_i  (eng_rx_push_i),
    .en_o       (en),
    .srst_o     (srst),
    .scl_low_o  (scl_low_o),
    .scl_high_o (scl_high_o),
    .own_o      (own_addr_o),
    .rx_cnt_o   (rx_cnt),
    .tx_cnt_o   (tx_cnt)
  );

  always_comb begin
    rdata_o = '0;
    case (sel)
      W_DATA: rdata_o = 32'(rx_dout);
      W_STAT: rdata_o = 32'(stat);
      W_CTL:  rdata_o = 32'({srst, en});
      W_SCLL: rdata_o = 32'(scl_low_o);
      W_SCLH: rdata_o = 32'(scl_high_o);
      W_OWN:  rdata_o = 32'(own_addr_o);
      W_RXL:  rdata_o = 32'(rx_lvl);
      W_TXL:  rdata_o = 32'(tx_lvl);
      W_RXB:  rdata_o = 32'(rx_cnt);
      W_TXB:  rdata_o = 32'(tx_cnt);
      default: rdata_o = '0;
    endcase
  end

  p_srst_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (tx_lvl == '0 && rx_lvl == '0));
  p_cmd_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == W_DATA && !srst) |=> eng_cmd_valid_o);
endmodule

// File: tb/sim_i2c_regfront.sv
module sim_i2c_regfront;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  logic [9:0] cmd;
  logic cmd_valid, cmd_pop = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_push = 1'b0, done = 1'b0, arb = 1'b0, nack = 1'b0, drq = 1'b0;
  logic active = 1'b0, scl = 1'b0, sda = 1'b0, start = 1'b0, tx_byte = 1'b0;
  logic eng_rst;
  logic [15:0] scl_lo, scl_hi;
  logic [6:0] own;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2c_regfront u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr_en), .rd_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .eng_cmd_o(cmd), .eng_cmd_valid_o(cmd_valid), .eng_cmd_pop_i(cmd_pop),
    .eng_rx_data_i(rx_data), .eng_rx_push_i(rx_push), .eng_done_i(done),
    .eng_arb_lost_i(arb), .eng_nack_i(nack), .eng_drq_i(drq),
    .eng_active_i(active), .eng_scl_i(scl), .eng_sda_i(sda),
    .eng_start_i(start), .eng_tx_byte_i(tx_byte), .eng_reset_o(eng_rst),
    .scl_low_o(scl_lo), .scl_high_o(scl_hi), .own_addr_o(own)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // 0 done, 1 arb, 2 start, 3 tx byte
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: done = 1'b1;
      1: arb = 1'b1;
      2: start = 1'b1;
      default: tx_byte = 1'b1;
    endcase
    @(negedge clk);
    done = 1'b0; arb = 1'b0; start = 1'b0; tx_byte = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_data = b; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic soft_reset();
    wr(8'h08, 32'h100);
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [9:0] txv(input int i);
    return 10'((i * 155 + 16'h3A5) & 16'h3FF);
  endfunction
  function automatic logic [7:0] rxv(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [7:0] srcv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(8'h08, d); chk("R1 ctl", d, 32'h0);
    peek(8'h0C, d); chk("R1 scl low", d, 32'hFF);
    peek(8'h10, d); chk("R1 scl high", d, 32'hFF);
    peek(8'h18, d); chk("R1 rx level", d, 0);
    peek(8'h1C, d); chk("R1 tx level", d, 0);
    peek(8'h04, d); chk("R1 status", d, 32'hA00);
    chk("R1 irq", 32'(irq), 0);

    // R2 / R3 TX queue fill and overrun
    for (int i = 0; i < 4; i++) begin
      wr(8'h00, 32'hFFFF_FC00 | 32'(txv(i)));
      peek(8'h1C, d); chk("R2 tx level", d, 32'(i + 1));
    end
    peek(8'h04, d);
    chk("R3 tx full bit10", 32'(d[10]), 1);
    chk("R3 tx empty bit11", 32'(d[11]), 0);
    wr(8'h00, 32'h0AA);
    peek(8'h1C, d); chk("R3 write to full ignored", d, 4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 cmd valid", 32'(cmd_valid), 1);
      chk("R2 cmd order", 32'(cmd), 32'(txv(i)));
      cmd_pop = 1'b1;
      @(negedge clk); cmd_pop = 1'b0;
    end
    chk("R2 cmd valid drops", 32'(cmd_valid), 0);

    // R4 RX queue
    for (int i = 0; i < 4; i++) push_rx(rxv(i));
    peek(8'h04, d); chk("R4 rx full bit8", 32'(d[8]), 1);
    push_rx(8'hEE);
    peek(8'h18, d); chk("R4 push to full dropped", d, 4);
    for (int i = 0; i < 4; i++) begin
      rd(8'h00, d); chk("R4 rx order", d, 32'(rxv(i)));
      peek(8'h18, d); chk("R4 rx level", d, 32'(3 - i));
    end
    rd(8'h00, d); chk("R4 empty read zero", d, 0);
    peek(8'h18, d); chk("R4 empty read level", d, 0);
    push_rx(8'h5C);
    rd(8'h00, d); chk("R4 pointer kept", d, 32'h5C);

    // R5 sticky write-1-to-clear
    pulse(0);
    peek(8'h04, d); chk("R5 done set", 32'(d[0]), 1);
    wr(8'h04, 32'h0);
    peek(8'h04, d); chk("R5 write 0 keeps", 32'(d[0]), 1);
    wr(8'h04, 32'h1);
    peek(8'h04, d); chk("R5 done cleared", 32'(d[0]), 0);
    pulse(1);
    peek(8'h04, d); chk("R5 arb set", 32'(d[1]), 1);
    wr(8'h04, 32'h1);
    peek(8'h04, d); chk("R5 arb kept by other bit", 32'(d[1]), 1);
    wr(8'h04, 32'h2);
    peek(8'h04, d); chk("R5 arb cleared", 32'(d[1]), 0);

    // R6 live bits
    for (int b = 0; b < 5; b++) begin
      nack = (b == 0); drq = (b == 1); active = (b == 2); scl = (b == 3); sda = (b == 4);
      wr(8'h04, 32'hFFC);
      peek(8'h04, d);
      chk("R6 live status", d, 32'hA00 | (32'(nack) << 2) | (32'(drq) << 3)
          | (32'(active) << 5) | (32'(scl) << 6) | (32'(sda) << 7));
    end
    nack = 0; drq = 0; active = 0; scl = 0; sda = 0;

    // R7 read/write registers
    wr(8'h08, 32'hA5);
    peek(8'h08, d); chk("R7 ctl", d, 32'hA5);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h1234);
    wr(8'h10, 32'h0F0E);
    wr(8'h14, 32'h5A);
    peek(8'h0C, d); chk("R7 scl low", d, 32'h1234);
    peek(8'h10, d); chk("R7 scl high", d, 32'h0F0E);
    peek(8'h14, d); chk("R7 own", d, 32'h5A);
    chk("R7 ports", {scl_lo, scl_hi}, 32'h1234_0F0E);
    chk("R7 own port", 32'(own), 32'h5A);

    // R8 soft reset
    wr(8'h00, 32'h11); wr(8'h00, 32'h22);
    push_rx(8'h33); push_rx(8'h44);
    wr(8'h08, 32'h100);
    peek(8'h08, d); chk("R8 bit reads 1", d, 32'h100);
    chk("R8 engine reset high", 32'(eng_rst), 1);
    repeat (6) @(negedge clk);
    peek(8'h08, d); chk("R8 bit self clears", d, 0);
    chk("R8 engine reset low", 32'(eng_rst), 0);
    peek(8'h18, d); chk("R8 rx flushed", d, 0);
    peek(8'h1C, d); chk("R8 tx flushed", d, 0);

    // R9 interrupt sweep: every source against every single enable
    for (int s = 0; s < 7; s++) begin
      case (s)
        0: begin pulse(0); srcv = 8'h01; end
        1: begin pulse(1); srcv = 8'h02; end
        2: begin nack = 1'b1; srcv = 8'h04; end
        3: begin drq = 1'b1; srcv = 8'h08; end
        4: begin for (int i = 0; i < 4; i++) push_rx(8'(i)); srcv = 8'h60; end
        5: begin push_rx(8'h77); srcv = 8'h40; end
        default: begin for (int i = 0; i < 4; i++) wr(8'h00, 32'(i)); srcv = 8'h80; end
      endcase
      for (int e = 0; e < 8; e++) begin
        wr(8'h08, 32'(1) << e);
        @(negedge clk);
        chk($sformatf("R9 irq src%0d en%0d", s, e), 32'(irq), 32'(srcv[e]));
      end
      wr(8'h08, 32'h0);
      case (s)
        0: wr(8'h04, 32'h1);
        1: wr(8'h04, 32'h2);
        2: nack = 1'b0;
        3: drq = 1'b0;
        default: soft_reset();
      endcase
      wr(8'h08, 32'hFF);
      @(negedge clk);
      chk("R9 irq idle after cleanup", 32'(irq), 0);
      wr(8'h08, 32'h0);
    end

    // R10 byte counters
    pulse(2);
    for (int i = 0; i < 3; i++) pulse(3);
    push_rx(8'h01); push_rx(8'h02);
    peek(8'h20, d); chk("R10 rx bytes", d, 2);
    peek(8'h24, d); chk("R10 tx bytes", d, 3);
    pulse(2);
    peek(8'h20, d); chk("R10 rx cleared by start", d, 0);
    peek(8'h24, d); chk("R10 tx cleared by start", d, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule